// File: doc/BRIEF.md
# Single-Wire Memory Bus Transaction Sequencer

This block is the master-side sequencer for a self-clocked, one-wire serial memory bus. A host hands it one request: an operation, a 16-bit word address, a byte count and up to `MAX_BYTES` bytes of write data. The sequencer turns the request into a series of byte operations for a separate bit engine. Each attempt opens with a standby pulse and the start header, then sends the device address, the command byte, the address bytes when needed, and finally the data bytes, which are sent or received. After every byte it tells the bit engine whether to send a master acknowledge (continue) or a master not-acknowledge (stop).

The bit engine returns the slave acknowledge bit and any received byte. The slave never acknowledges the start header, so the sequencer ignores that bit. A missing slave acknowledge after any later byte aborts the attempt. The sequencer then sends a fresh standby pulse and replays the whole command from the header. A parameter bounds the number of replays. Read bytes are passed to the host one at a time with a strobe. When the request ends, a one-cycle done pulse presents a status code.

Top module: `swireSeq`

## Requirements
- R1: After reset, `reqReady` is 1, `beReq` is 0 and `done` is 0.
- R2: Every attempt starts with a standby operation (`beOp`=0), followed by a header operation (`beOp`=1) with `beMak`=1. The acknowledge bit returned for the header has no effect on the sequence or the status.
- R3: After the header, the device address byte 0xA0 is sent (`beOp`=2) with `beMak`=1. The command byte follows. Its code depends on `reqOp`: 0 READ→0x03, 1 CRRD→0x06, 2 RDSR→0x05, 3 WRITE→0x6C, 4 WRSR→0x6E, 5 WREN→0x96, 6 WRDI→0x91, 7 ERAL→0x6D, 8 SETAL→0x67. Codes 9 to 15 act as WRDI.
- R4: For READ and WRITE only, the high address byte and then the low address byte are sent after the command, each with `beMak`=1.
- R5: READ, CRRD and RDSR receive `reqCount`+1 bytes (`beOp`=3). WRITE sends `reqCount`+1 bytes of `reqWrData`, lowest byte first. WRSR sends exactly one byte, `reqWrData[7:0]`, whatever the value of `reqCount`. WREN, WRDI, ERAL and SETAL send no data.
- R6: Every byte except the final one of an attempt carries `beMak`=1. The final byte carries `beMak`=0: the command byte for WREN, WRDI, ERAL and SETAL, otherwise the last data byte. When the slave acknowledges the final byte, `done` pulses on the next cycle.
- R7: Each received byte that the slave acknowledges is presented on `rdData` with a one-cycle `rdValid` pulse, one cycle after its `beDone`. Bytes from an aborted attempt that were acknowledged are also presented. Bytes that were not acknowledged are not.
- R8: A slave acknowledge of 0 on any byte after the header ends the attempt. If fewer than `MAX_RETRY` restarts have been used, a new standby operation follows at once and the full command is replayed.
- R9: `done` is a one-cycle pulse with `status` 0 for success on the first attempt, 1 for success after at least one restart, and 2 when attempt `MAX_RETRY`+1 also fails. No further bit-engine operation is issued after a failure.
- R10: While `beReq` is high and `beDone` is low, `beOp`, `beTxByte` and `beMak` stay constant. The next operation is presented in the cycle after `beDone`.
- R11: A request is taken only while `reqReady` is high. `reqReady` is low from acceptance until after the `done` pulse, and it is never high together with `beReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Sequencer idle and able to take a request |
| reqOp | input | 4 | Host operation code (see R3) |
| reqAddr | input | 16 | Word address for READ and WRITE |
| reqCount | input | $clog2(MAX_BYTES) | Number of data bytes minus one |
| reqWrData | input | MAX_BYTES*8 | Write data, byte 0 in bits 7:0 |
| rdValid | output | 1 | Received byte strobe |
| rdData | output | 8 | Received byte |
| done | output | 1 | Request finished, one-cycle pulse |
| status | output | 2 | 0 ok, 1 ok after restart, 2 failed |
| beReq | output | 1 | Bit-engine operation pending |
| beOp | output | 2 | 0 standby, 1 header, 2 send byte, 3 receive byte |
| beTxByte | output | 8 | Byte to send for `beOp`=2 |
| beMak | output | 1 | Master acknowledge bit to send after the byte |
| beDone | input | 1 | Bit engine finished the pending operation |
| beSak | input | 1 | Slave acknowledge seen, valid with `beDone` |
| beRxByte | input | 8 | Received byte, valid with `beDone` |

## Verification
The in-RTL assertions check several properties on every cycle: the bit-engine fields stay stable during a handshake, a standby is always followed by a header with a master acknowledge, a failed slave acknowledge leads straight to a standby or to `done`, an acknowledged not-acknowledge byte ends in `done`, `done` lasts one cycle, the restart counter stays within bounds, and `reqReady` is never high together with `beReq`. Some behaviour only the bench scenarios can show, because it depends on a whole transaction: the exact order of bytes and acknowledge bits for each operation, the replayed byte streams, the read bytes from each attempt, and the final status. For these, a bit-engine model injects slave not-acknowledges at chosen byte positions and over chosen numbers of attempts.

// File: rtl/swirePkg.sv
package swirePkg;

  typedef enum logic [1:0] {
    BE_STBY = 2'd0,
    BE_HDR  = 2'd1,
    BE_TX   = 2'd2,
    BE_RX   = 2'd3
  } beOp_e;

  typedef enum logic [2:0] {
    SEL_DEV,
    SEL_CMD,
    SEL_AHI,
    SEL_ALO,
    SEL_DATA
  } txSel_e;

  localparam logic [3:0] OP_READ  = 4'd0;
  localparam logic [3:0] OP_CRRD  = 4'd1;
  localparam logic [3:0] OP_RDSR  = 4'd2;
  localparam logic [3:0] OP_WRITE = 4'd3;
  localparam logic [3:0] OP_WRSR  = 4'd4;
  localparam logic [3:0] OP_WREN  = 4'd5;
  localparam logic [3:0] OP_WRDI  = 4'd6;
  localparam logic [3:0] OP_ERAL  = 4'd7;
  localparam logic [3:0] OP_SETAL = 4'd8;

  localparam logic [1:0] ST_OK    = 2'd0;
  localparam logic [1:0] ST_RETRY = 2'd1;
  localparam logic [1:0] ST_FAIL  = 2'd2;

  localparam logic [7:0] DEV_ADDR = 8'hA0;

  typedef struct packed {
    logic   latch;
    logic   clrIdx;
    logic   incIdx;
    logic   clrRetry;
    logic   incRetry;
    logic   capRx;
    logic   setOk;
    logic   setFail;
    txSel_e sel;
  } ctlStb_t;

  function automatic logic [7:0] cmdCode(input logic [3:0] op);
    case (op)
      OP_READ:  cmdCode = 8'h03;
      OP_CRRD:  cmdCode = 8'h06;
      OP_RDSR:  cmdCode = 8'h05;
      OP_WRITE: cmdCode = 8'h6C;
      OP_WRSR:  cmdCode = 8'h6E;
      OP_WREN:  cmdCode = 8'h96;
      OP_ERAL:  cmdCode = 8'h6D;
      OP_SETAL: cmdCode = 8'h67;
      default:  cmdCode = 8'h91;
    endcase
  endfunction

endpackage

// File: rtl/swireDatapath.sv
module swireDatapath
  import swirePkg::*;
#(
  parameter int MAX_BYTES = 4,
  parameter int MAX_RETRY = 3,
  localparam int IW = $clog2(MAX_BYTES),
  localparam int RW = $clog2(MAX_RETRY + 1),
  localparam int DW = MAX_BYTES * 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStb_t       stb,
  input  logic [3:0]    reqOp,
  input  logic [15:0]   reqAddr,
  input  logic [IW-1:0] reqCount,
  input  logic [DW-1:0] reqWrData,
  input  logic [7:0]    beRxByte,
  output logic [7:0]    txByte,
  output logic          hasAddr,
  output logic          cmdOnly,
  output logic          dataRx,
  output logic          lastData,
  output logic          retryDone,
  output logic [1:0]    status,
  output logic          rdValid,
  output logic [7:0]    rdData
);

  logic [3:0]    opR;
  logic [15:0]   addrR;
  logic [IW-1:0] cntR;
  logic [IW-1:0] idx;
  logic [DW-1:0] wdR;
  logic [DW-1:0] wdShift;
  logic [RW-1:0] retryCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opR      <= OP_WRDI;
      addrR    <= '0;
      cntR     <= '0;
      wdR      <= '0;
      idx      <= '0;
      retryCnt <= '0;
      status   <= ST_OK;
      rdValid  <= 1'b0;
      rdData   <= '0;
    end else begin
      if (stb.latch) begin
        opR   <= reqOp;
        addrR <= reqAddr;
        cntR  <= reqCount;
        wdR   <= reqWrData;
      end
      if (stb.clrIdx)      idx <= '0;
      else if (stb.incIdx) idx <= idx + 1'b1;
      if (stb.clrRetry)      retryCnt <= '0;
      else if (stb.incRetry) retryCnt <= retryCnt + 1'b1;
      if (stb.setOk)        status <= (retryCnt == '0) ? ST_OK : ST_RETRY;
      else if (stb.setFail) status <= ST_FAIL;
      rdValid <= stb.capRx;
      if (stb.capRx) rdData <= beRxByte;
    end
  end

  always_comb begin
    hasAddr  = (opR == OP_READ) || (opR == OP_WRITE);
    dataRx   = (opR == OP_READ) || (opR == OP_CRRD) || (opR == OP_RDSR);
    cmdOnly  = !dataRx && (opR != OP_WRITE) && (opR != OP_WRSR);
    lastData = (opR == OP_WRSR) || (idx == cntR);
    retryDone = (retryCnt == RW'(MAX_RETRY));
  end

  assign wdShift = wdR >> {idx, 3'b000};

  always_comb begin
    case (stb.sel)
      SEL_CMD:  txByte = cmdCode(opR);
      SEL_AHI:  txByte = addrR[15:8];
      SEL_ALO:  txByte = addrR[7:0];
      SEL_DATA: txByte = wdShift[7:0];
      default:  txByte = DEV_ADDR;
    endcase
  end

  // R8
  retry_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.incRetry |-> (retryCnt < RW'(MAX_RETRY)));

  // R9
  fail_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.setFail |=> (status == ST_FAIL));

endmodule

// File: rtl/swireCtrl.sv
module swireCtrl
  import swirePkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    beDone,
  input  logic    beSak,
  input  logic    hasAddr,
  input  logic    cmdOnly,
  input  logic    dataRx,
  input  logic    lastData,
  input  logic    retryDone,
  output logic    reqReady,
  output logic    beReq,
  output beOp_e   beOp,
  output logic    beMak,
  output logic    done,
  output ctlStb_t stb
);

  typedef enum logic [3:0] {
    S_IDLE, S_STBY, S_HDR, S_DEV, S_CMD, S_AHI, S_ALO, S_DATA, S_FIN
  } state_e;

  state_e state, next;
  logic   fault, goodEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= next;
  end

  always_comb begin
    next     = state;
    stb      = '0;
    stb.sel  = SEL_DEV;
    beReq    = 1'b0;
    beOp     = BE_STBY;
    beMak    = 1'b0;
    reqReady = 1'b0;
    done     = 1'b0;
    fault    = 1'b0;
    goodEnd  = 1'b0;
    case (state)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          stb.latch    = 1'b1;
          stb.clrRetry = 1'b1;
          next         = S_STBY;
        end
      end
      S_STBY: begin
        beReq = 1'b1;
        if (beDone) begin
          stb.clrIdx = 1'b1;
          next       = S_HDR;
        end
      end
      S_HDR: begin
        beReq = 1'b1;
        beOp  = BE_HDR;
        beMak = 1'b1;
        if (beDone) next = S_DEV;
      end
      S_DEV: begin
        beReq = 1'b1;
        beOp  = BE_TX;
        beMak = 1'b1;
        if (beDone) begin
          if (!beSak) fault = 1'b1;
          else        next  = S_CMD;
        end
      end
      S_CMD: begin
        beReq   = 1'b1;
        beOp    = BE_TX;
        beMak   = !cmdOnly;
        stb.sel = SEL_CMD;
        if (beDone) begin
          if (!beSak)       fault   = 1'b1;
          else if (cmdOnly) goodEnd = 1'b1;
          else if (hasAddr) next    = S_AHI;
          else              next    = S_DATA;
        end
      end
      S_AHI: begin
        beReq   = 1'b1;
        beOp    = BE_TX;
        beMak   = 1'b1;
        stb.sel = SEL_AHI;
        if (beDone) begin
          if (!beSak) fault = 1'b1;
          else        next  = S_ALO;
        end
      end
      S_ALO: begin
        beReq   = 1'b1;
        beOp    = BE_TX;
        beMak   = 1'b1;
        stb.sel = SEL_ALO;
        if (beDone) begin
          if (!beSak) fault = 1'b1;
          else        next  = S_DATA;
        end
      end
      S_DATA: begin
        beReq   = 1'b1;
        beOp    = dataRx ? BE_RX : BE_TX;
        beMak   = !lastData;
        stb.sel = SEL_DATA;
        if (beDone) begin
          if (!beSak) fault = 1'b1;
          else begin
            stb.capRx = dataRx;
            if (lastData) goodEnd    = 1'b1;
            else          stb.incIdx = 1'b1;
          end
        end
      end
      S_FIN: begin
        done = 1'b1;
        next = S_IDLE;
      end
      default: next = S_IDLE;
    endcase
    if (fault) begin
      if (retryDone) begin
        stb.setFail = 1'b1;
        next        = S_FIN;
      end else begin
        stb.incRetry = 1'b1;
        next         = S_STBY;
      end
    end
    if (goodEnd) begin
      stb.setOk = 1'b1;
      next      = S_FIN;
    end
  end

  // R2
  hdr_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (beReq && beOp == BE_STBY && beDone) |=> (beReq && beOp == BE_HDR && beMak));

  // R8
  fault_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (beReq && beDone && !beSak && (beOp == BE_TX || beOp == BE_RX))
      |=> ((beReq && beOp == BE_STBY) || done));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && reqReady));

  // R11
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(reqReady && beReq));

endmodule

// File: rtl/swireSeq.sv
module swireSeq
  import swirePkg::*;
#(
  parameter int MAX_BYTES = 4,
  parameter int MAX_RETRY = 3,
  localparam int IW = $clog2(MAX_BYTES),
  localparam int DW = MAX_BYTES * 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic [3:0]    reqOp,
  input  logic [15:0]   reqAddr,
  input  logic [IW-1:0] reqCount,
  input  logic [DW-1:0] reqWrData,
  output logic          rdValid,
  output logic [7:0]    rdData,
  output logic          done,
  output logic [1:0]    status,
  output logic          beReq,
  output logic [1:0]    beOp,
  output logic [7:0]    beTxByte,
  output logic          beMak,
  input  logic          beDone,
  input  logic          beSak,
  input  logic [7:0]    beRxByte
);

  ctlStb_t stb;
  beOp_e   opKind;
  logic    hasAddr, cmdOnly, dataRx, lastData, retryDone;

  assign beOp = opKind;

  swireCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .beDone    (beDone),
    .beSak     (beSak),
    .hasAddr   (hasAddr),
    .cmdOnly   (cmdOnly),
    .dataRx    (dataRx),
    .lastData  (lastData),
    .retryDone (retryDone),
    .reqReady  (reqReady),
    .beReq     (beReq),
    .beOp      (opKind),
    .beMak     (beMak),
    .done      (done),
    .stb       (stb)
  );

  swireDatapath #(
    .MAX_BYTES (MAX_BYTES),
    .MAX_RETRY (MAX_RETRY)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .reqOp     (reqOp),
    .reqAddr   (reqAddr),
    .reqCount  (reqCount),
    .reqWrData (reqWrData),
    .beRxByte  (beRxByte),
    .txByte    (beTxByte),
    .hasAddr   (hasAddr),
    .cmdOnly   (cmdOnly),
    .dataRx    (dataRx),
    .lastData  (lastData),
    .retryDone (retryDone),
    .status    (status),
    .rdValid   (rdValid),
    .rdData    (rdData)
  );

  // R10
  be_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (beReq && !beDone) |=> (beReq && $stable(beOp) && $stable(beTxByte) && $stable(beMak)));

  // R6
  nomak_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (beReq && beDone && beSak && !beMak && (beOp == 2'd2 || beOp == 2'd3)) |=> done);

endmodule

// File: tb/swireSeq_bench.sv
module swireSeq_bench;

  localparam int MAXB  = 4;
  localparam int MAXR  = 3;
  localparam int IW    = $clog2(MAXB);
  localparam int DW    = MAXB * 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [3:0]    reqOp = '0;
  logic [15:0]   reqAddr = '0;
  logic [IW-1:0] reqCount = '0;
  logic [DW-1:0] reqWrData = '0;
  logic          rdValid;
  logic [7:0]    rdData;
  logic          done;
  logic [1:0]    status;
  logic          beReq;
  logic [1:0]    beOp;
  logic [7:0]    beTxByte;
  logic          beMak;
  logic          beDone = 1'b0;
  logic          beSak = 1'b0;
  logic [7:0]    beRxByte = '0;

  always #4 clk = ~clk;

  swireSeq #(.MAX_BYTES(MAXB), .MAX_RETRY(MAXR)) u_swireSeq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqCount(reqCount), .reqWrData(reqWrData),
    .rdValid(rdValid), .rdData(rdData), .done(done), .status(status),
    .beReq(beReq), .beOp(beOp), .beTxByte(beTxByte), .beMak(beMak),
    .beDone(beDone), .beSak(beSak), .beRxByte(beRxByte)
  );

  int checks = 0;
  int errors = 0;

  logic [10:0] expSeq [0:255];
  logic [10:0] obsSeq [0:255];
  logic [7:0]  expRd  [0:255];
  logic [7:0]  obsRd  [0:255];
  int expN, obsN, expRdN, obsRdN;

  int attemptNo, posInAtt, rxIdx, nFailM, failPosM;
  bit hdrSakM;
  bit doneSeen;
  logic [1:0] doneStat;

  function automatic logic [7:0] codeOf(input logic [3:0] op);
    case (op)
      4'd0: return 8'h03; 4'd1: return 8'h06; 4'd2: return 8'h05;
      4'd3: return 8'h6C; 4'd4: return 8'h6E; 4'd5: return 8'h96;
      4'd7: return 8'h6D; 4'd8: return 8'h67; default: return 8'h91;
    endcase
  endfunction

  function automatic bit isRx(input logic [3:0] op);
    return op <= 4'd2;
  endfunction

  function automatic bit withAddr(input logic [3:0] op);
    return op == 4'd0 || op == 4'd3;
  endfunction

  function automatic int dataCount(input logic [3:0] op, input int cnt);
    if (op == 4'd4) return 1;
    if (op <= 4'd3) return cnt + 1;
    return 0;
  endfunction

  function automatic logic [7:0] rxVal(input logic [15:0] a, input int k);
    return 8'(a[7:0] + 8'(3 * k) + 8'h11);
  endfunction

  // Bit-engine model
  initial begin
    forever begin
      @(negedge clk);
      beDone = 1'b0;
      if (beReq && rstN) begin
        logic [1:0] k;
        logic       m;
        logic [7:0] b;
        logic       s;
        k = beOp; m = (k == 2'd0) ? 1'b0 : beMak; b = (k == 2'd2) ? beTxByte : 8'h00;
        s = 1'b1;
        if (k == 2'd0) begin attemptNo++; posInAtt = 0; rxIdx = 0; end
        else if (k == 2'd1) s = hdrSakM;
        else begin
          posInAtt++;
          s = !(attemptNo <= nFailM && posInAtt == failPosM);
          if (k == 2'd3) begin beRxByte = rxVal(reqAddr, rxIdx); rxIdx++; end
        end
        if (obsN < 256) obsSeq[obsN] = {k, m, b};
        obsN++;
        repeat ($urandom_range(0, 3)) @(negedge clk);
        beSak  = s;
        beDone = 1'b1;
      end
    end
  end

  // Output monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (rdValid) begin
        if (obsRdN < 256) obsRd[obsRdN] = rdData;
        obsRdN++;
      end
      if (done) begin doneSeen = 1'b1; doneStat = status; end
    end
  end

  task automatic pushExp(input logic [1:0] k, input logic m, input logic [7:0] b);
    if (expN < 256) expSeq[expN] = {k, m, b};
    expN++;
  endtask

  task automatic buildAttempt(input logic [3:0] op, input logic [15:0] a, input int cnt,
                              input logic [DW-1:0] wd, input int fp);
    int pos = 0;
    int nd  = dataCount(op, cnt);
    pushExp(2'd0, 1'b0, 8'h00);
    pushExp(2'd1, 1'b1, 8'h00);
    pos++; pushExp(2'd2, 1'b1, 8'hA0);
    if (pos == fp) return;
    pos++; pushExp(2'd2, nd != 0, codeOf(op));
    if (pos == fp) return;
    if (withAddr(op)) begin
      pos++; pushExp(2'd2, 1'b1, a[15:8]);
      if (pos == fp) return;
      pos++; pushExp(2'd2, 1'b1, a[7:0]);
      if (pos == fp) return;
    end
    for (int d = 0; d < nd; d++) begin
      pos++;
      if (isRx(op)) pushExp(2'd3, d != nd - 1, 8'h00);
      else          pushExp(2'd2, d != nd - 1, wd[d*8 +: 8]);
      if (pos == fp) return;
      if (isRx(op)) begin
        if (expRdN < 256) expRd[expRdN] = rxVal(a, d);
        expRdN++;
      end
    end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic runTxn(input logic [3:0] op, input logic [15:0] a, input int cnt,
                        input logic [DW-1:0] wd, input int nF, input int fP,
                        input bit hSak, input string req);
    int attempts = (nF > MAXR) ? MAXR + 1 : nF + 1;
    logic [1:0] expStat = (nF > MAXR) ? 2'd2 : (nF > 0) ? 2'd1 : 2'd0;
    int t = 0;
    int bad;
    expN = 0; expRdN = 0;
    for (int i = 1; i <= attempts; i++) buildAttempt(op, a, cnt, wd, (i <= nF) ? fP : 0);
    while (!reqReady) @(negedge clk);
    obsN = 0; obsRdN = 0; doneSeen = 1'b0;
    attemptNo = 0; nFailM = nF; failPosM = fP; hdrSakM = hSak;
    reqOp = op; reqAddr = a; reqCount = IW'(cnt); reqWrData = wd; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (!doneSeen && t < 3000) begin @(negedge clk); t++; end
    check(doneSeen, "R9", "done seen", int'(doneSeen), 1);
    check(doneStat == expStat, {req, " R9"}, "status", int'(doneStat), int'(expStat));
    check(obsN == expN, {req, " R8"}, "op count", obsN, expN);
    bad = -1;
    for (int i = 0; i < expN && i < 256; i++)
      if (bad < 0 && (i >= obsN || obsSeq[i] !== expSeq[i])) bad = i;
    check(bad < 0, {req, " R3 R6"}, "op sequence",
          (bad < 0) ? 0 : int'(obsSeq[bad]), (bad < 0) ? 0 : int'(expSeq[bad]));
    check(obsRdN == expRdN, "R7", "read count", obsRdN, expRdN);
    bad = -1;
    for (int i = 0; i < expRdN && i < 256; i++)
      if (bad < 0 && obsRd[i] !== expRd[i]) bad = i;
    check(bad < 0, "R7", "read data",
          (bad < 0) ? 0 : int'(obsRd[bad]), (bad < 0) ? 0 : int'(expRd[bad]));
    repeat (2) @(negedge clk);
    check(reqReady && !beReq, "R11", "idle after done", int'({reqReady, beReq}), 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(reqReady === 1'b1, "R1", "reqReady after reset", int'(reqReady), 1);
    check(beReq === 1'b0 && done === 1'b0, "R1", "beReq/done after reset",
          int'({beReq, done}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady === 1'b1 && beReq === 1'b0, "R1", "idle after release",
          int'({reqReady, beReq}), 2);
    // Directed cases
    runTxn(4'd5, 16'h0000, 0, '0, 0, 0, 1'b0, "R6 WREN");
    runTxn(4'd8, 16'h0000, 0, '0, 0, 0, 1'b1, "R2 header ack ignored");
    runTxn(4'd4, 16'h0000, 3, 32'hDEADBE5A, 1, 2, 1'b0, "R5 WRSR one byte");
    runTxn(4'd0, 16'h12F0, 3, '0, 2, 7, 1'b0, "R4 R8 READ late fault");
    runTxn(4'd3, 16'hABCD, 3, 32'h44332211, MAXR + 1, 3, 1'b0, "R9 WRITE exhausted");
    runTxn(4'd3, 16'h0102, 1, 32'h0000BEEF, MAXR, 1, 1'b0, "R8 WRITE max restarts");
    runTxn(4'd1, 16'h0040, 2, '0, 0, 0, 1'b0, "R5 CRRD");
    runTxn(4'd2, 16'h0007, 0, '0, 1, 3, 1'b0, "R7 RDSR fault on data");
    runTxn(4'd12, 16'h0000, 0, '0, 0, 0, 1'b0, "R3 unused code");
    // Random cases
    for (int n = 0; n < 30; n++) begin
      logic [3:0] op = 4'($urandom_range(0, 8));
      int cnt = $urandom_range(0, MAXB - 1);
      int nb  = 2 + (withAddr(op) ? 2 : 0) + dataCount(op, cnt);
      int nF  = ($urandom_range(0, 2) == 0) ? 0 : $urandom_range(1, MAXR + 1);
      runTxn(op, 16'($urandom), cnt, DW'($urandom), nF, $urandom_range(1, nb),
             1'($urandom_range(0, 1)), "R5 random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule